// File: doc/BRIEF.md
# Oversampled Edge Pattern Capture

This block records a fingerprint of link quality while a serial encoder link starts up. The receive line is sampled eight times per cable bit, and a phase counter gives each sample its slot within the bit. When a sample differs from the sample just before it, the block sets a sticky flag for that sample's slot. The eight flags form a pattern that can only be read. A clean line sets only a few flags, clustered near the bit boundary. A noisy line sets many of them.

The pattern is gathered only while the start-up qualifier is high. Once start-up ends, the pattern is frozen. It is cleared, and a new capture is allowed, only by a forced protocol reset. An extra output goes high when all eight slots have seen an edge. That condition means the line is too noisy for a connection to be made.

Top module: `edge_pattern_capture`

## Requirements
- R1: A phase counter starts at 0 after reset, advances by one on each cycle with `sample_en` high, and wraps from 7 to 0. Pattern bit i belongs to the sample taken while the counter equals i.
- R2: An edge is a sample whose line value differs from the immediately preceding sample. An edge sets the pattern bit of its slot, and the bit then stays set. The first sample after a reset has no predecessor and is never an edge.
- R3: On a cycle with `sample_en` low, the line is ignored. Neither the pattern nor the sample history changes.
- R4: Edges are recorded only while `startup_active` is high. After `startup_active` has been high and then falls, the pattern is frozen, even if `startup_active` rises again.
- R5: `proto_reset` clears the pattern, the phase counter, the sample history and the frozen state. A new capture then happens on the next start-up.
- R6: `all_edges` goes high one cycle after the pattern reaches 8'hFF. It stays high until a reset.
- R7: A synchronous `rst` sets the pattern to 8'h00 and `all_edges` to 0, and has priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Oversampling strobe, one per sample |
| line_in | input | 1 | Sampled cable line value |
| startup_active | input | 1 | High while the link is in its start-up phase |
| proto_reset | input | 1 | Forced protocol reset, clears and re-arms the capture |
| pattern | output | 8 | Per-phase edge pattern, read-only |
| all_edges | output | 1 | High when every phase has seen an edge |

## Verification
Some properties are checked by assertions on every cycle:
- pattern bits never fall without a reset;
- at most one bit is newly set in any cycle;
- the pattern is stable once frozen;
- the phase counter wraps from 7 to 0;
- `all_edges` implies a full pattern.

Other behaviour shows only in the bench's scenarios: which slot a transition lands in, that a held strobe ignores line activity, that a second start-up window does not reopen capture, and that the first sample after a protocol reset is not counted. A behavioural model in the bench follows every clock and is compared against the outputs on each cycle.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int DEF_PHASES = 8;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_DONE  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/ecap_phase_ctr.sv
module ecap_phase_ctr #(
  parameter int PHASES = 8,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (step) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // R1: the counter wraps from the last slot back to zero
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && phase == LAST) |=> (phase == '0));
endmodule

// File: rtl/ecap_edge_det.sv
module ecap_edge_det #(
  parameter int PHASES = 8,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic              line,
  input  logic [PW-1:0]     phase,
  output logic [PHASES-1:0] hit_vec
);
  logic prev_q;
  logic have_prev_q;
  logic edge_now;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (step) begin
      prev_q      <= line;
      have_prev_q <= 1'b1;
    end
  end

  assign edge_now = step && have_prev_q && (line != prev_q);

  for (genvar i = 0; i < PHASES; i++) begin : g_hit
    assign hit_vec[i] = edge_now && (phase == PW'(i));
  end

  // R3: with no strobe the held sample does not move
  p_hold_prev_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(prev_q) && $stable(have_prev_q));
endmodule

// File: rtl/ecap_pattern_store.sv
module ecap_pattern_store
  import ecap_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              startup,
  input  logic [PHASES-1:0] hit_vec,
  output logic [PHASES-1:0] pattern,
  output logic              all_edges
);
  cap_state_t state_q;
  logic       capture_ok;

  assign capture_ok = startup && (state_q != CAP_DONE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= CAP_IDLE;
    end else begin
      case (state_q)
        CAP_IDLE:  if (startup)  state_q <= CAP_ARMED;
        CAP_ARMED: if (!startup) state_q <= CAP_DONE;
        default:   state_q <= CAP_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pattern   <= '0;
      all_edges <= 1'b0;
    end else begin
      if (capture_ok) pattern <= pattern | hit_vec;
      all_edges <= &pattern;
    end
  end

  // R2: flags are sticky until a reset
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((pattern & $past(pattern)) == $past(pattern)));

  // R2: one sample per cycle sets at most one flag
  p_one_new_r2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ($countones(pattern & ~$past(pattern)) <= 1));

  // R4: frozen once the start-up window has closed
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAP_DONE && !clr) |=> $stable(pattern));

  // R5: a protocol reset empties the pattern
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pattern == '0 && !all_edges));

  // R6: the flag is only raised with a full pattern
  p_all_full_r6: assert property (@(posedge clk) disable iff (rst)
    all_edges |-> (&pattern));
endmodule

// File: rtl/edge_pattern_capture.sv
module edge_pattern_capture
  import ecap_pkg::*;
#(
  parameter int PHASES = DEF_PHASES,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic              line_in,
  input  logic              startup_active,
  input  logic              proto_reset,
  output logic [PHASES-1:0] pattern,
  output logic              all_edges
);
  logic [PW-1:0]     phase;
  logic [PHASES-1:0] hit_vec;

  ecap_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .clr   (proto_reset),
    .step  (sample_en),
    .phase (phase)
  );

  ecap_edge_det #(.PHASES(PHASES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .clr     (proto_reset),
    .step    (sample_en),
    .line    (line_in),
    .phase   (phase),
    .hit_vec (hit_vec)
  );

  ecap_pattern_store #(.PHASES(PHASES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (proto_reset),
    .startup   (startup_active),
    .hit_vec   (hit_vec),
    .pattern   (pattern),
    .all_edges (all_edges)
  );

  // R7: reset leaves the pattern empty
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (pattern == '0 && !all_edges));
endmodule

// File: tb/edge_pattern_capture_test.sv
module edge_pattern_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       line_in = 1'b0;
  logic       startup_active = 1'b0;
  logic       proto_reset = 1'b0;
  logic [7:0] pattern;
  logic       all_edges;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  int m_phase = 0, m_prev = 0, m_have = 0, m_pat = 0, m_all = 0, m_seen = 0, m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_pattern_capture uut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .line_in(line_in),
    .startup_active(startup_active), .proto_reset(proto_reset),
    .pattern(pattern), .all_edges(all_edges)
  );

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    if (rst || proto_reset) begin
      m_phase = 0; m_prev = 0; m_have = 0; m_pat = 0; m_all = 0; m_seen = 0; m_done = 0;
    end else begin
      int cap;
      cap = (startup_active && !m_done) ? 1 : 0;
      m_all = (m_pat == 255) ? 1 : 0;
      if (sample_en) begin
        if (cap && m_have && (int'(line_in) != m_prev)) m_pat = m_pat | (1 << m_phase);
        m_prev = int'(line_in);
        m_have = 1;
        m_phase = (m_phase + 1) % 8;
      end
      if (startup_active) m_seen = 1;
      else if (m_seen) m_done = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (int'(pattern) != m_pat || int'(all_edges) != m_all) begin
        bad++;
        $display("FAIL R1/R2/R6 per-cycle model: pattern=%02h all=%0d expected pattern=%02h all=%0d",
                 pattern, all_edges, m_pat[7:0], m_all);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input logic en, input logic ln, input logic st, input logic pr);
    @(negedge clk);
    sample_en = en; line_in = ln; startup_active = st; proto_reset = pr;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    @(negedge clk);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 pattern after reset", int'(pattern), 0);
    check("R7 all_edges after reset", int'(all_edges), 0);
    drive(0, 0, 0, 0);
    rst = 1'b0;

    // R1 R2: one transition per bit, landing in slot 3
    for (int k = 0; k < 40; k++) drive(1, logic'(((k + 5) / 8) % 2), 1, 0);
    drive(0, 0, 1, 0);
    check("R1 R2 clean line slot 3", int'(pattern), 8'h08);
    check("R6 not all edges", int'(all_edges), 0);

    // R3: line toggling without strobe
    for (int k = 0; k < 10; k++) drive(0, logic'(k % 2), 1, 0);
    check("R3 no strobe ignored", int'(pattern), 8'h08);

    // R4: window closes, noisy line afterwards, then start-up again
    drive(0, 0, 0, 0);
    for (int k = 0; k < 16; k++) drive(1, logic'(k % 2), 0, 0);
    drive(0, 0, 0, 0);
    check("R4 frozen after start-up", int'(pattern), 8'h08);
    for (int k = 0; k < 16; k++) drive(1, logic'(k % 2), 1, 0);
    drive(0, 0, 1, 0);
    check("R4 second window ignored", int'(pattern), 8'h08);

    // R5: protocol reset clears
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    check("R5 cleared by protocol reset", int'(pattern), 0);

    // R2 R6: toggling every sample fills all slots
    for (int k = 0; k < 10; k++) drive(1, logic'(k % 2), 1, 0);
    drive(0, 0, 1, 0);
    check("R2 noisy line all slots", int'(pattern), 8'hFF);
    check("R6 all_edges raised", int'(all_edges), 1);

    // R5 R2: first sample after protocol reset never counts; R1 next lands in slot 1
    drive(0, 1, 0, 1);
    drive(1, 0, 1, 0);
    drive(0, 0, 1, 0);
    check("R5 first sample after reset", int'(pattern), 0);
    check("R5 all_edges cleared", int'(all_edges), 0);
    drive(1, 1, 1, 0);
    drive(0, 1, 1, 0);
    check("R1 edge in slot 1", int'(pattern), 8'h02);

    // R7: reset mid-run has priority over capture
    @(negedge clk);
    rst = 1'b1; sample_en = 1'b1; line_in = 1'b0;
    @(negedge clk);
    rst = 1'b0; sample_en = 1'b0;
    check("R7 synchronous reset mid-run", int'(pattern), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule